// File: doc/BRIEF.md
# UART Interrupt Enable and Request Logic

This block holds the four-bit interrupt mask of a UART and merges the serial port's pending conditions into a single active-high interrupt request. Four sources are covered: received data available, transmit holding register empty, a receive line error, and a modem control line change. Each source is gated by its own mask bit. The request line is the OR of every gated source.

The mask is written and read through an 8-bit register port. Only the low four bits are kept, and the upper four bits always read as zero. The receive source has two modes. In FIFO mode it compares the receive FIFO fill count with a trigger level that the caller supplies. Outside FIFO mode it follows the single data-ready flag. The request is computed combinationally from the registered mask and the current status inputs, so a status change shows on the request in the same cycle.

The asynchronous active-low reset is released through a two-stage synchronizer. All logic runs from the synchronized reset.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is held, and after its release until the first write, the mask reads as 0x00 and `irq` stays low even when every source is pending.
- R2: A clock edge with `reg_wr` high stores `reg_wdata[3:0]` as the mask. From the next cycle `reg_rdata[3:0]` returns those bits and `reg_rdata[7:4]` reads 0.
- R3: Without `reg_wr` the mask keeps its value, whatever `reg_wdata` carries.
- R4: Mask bit 0 enables the receive source. When `fifo_mode` is 0, that source is pending exactly while `rx_data_ready` is 1.
- R5: When `fifo_mode` is 1, the receive source is pending while `rx_count` is nonzero and `rx_count >= rx_trigger`. It clears as soon as the count drops below the trigger. `rx_data_ready` is then ignored.
- R6: Mask bit 1 enables the transmit source, which is pending while `thr_empty` is 1.
- R7: Mask bit 2 enables the line status source, which is pending while `line_err` is 1.
- R8: Mask bit 3 enables the modem status source, which is pending while `modem_chg` is 1.
- R9: `irq` is the OR over all four sources of (mask bit AND pending). A source whose mask bit is 0 has no effect on `irq`.
- R10: `irq` follows a status input change in the same cycle, with no register in the path. A mask write affects `irq` from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Mask register write strobe |
| reg_wdata | input | 8 | Mask write data; bits 3:0 used |
| reg_rdata | output | 8 | Mask read data; bits 7:4 are zero |
| fifo_mode | input | 1 | 1 selects trigger-level compare for the receive source |
| rx_data_ready | input | 1 | Receive data available (non-FIFO mode) |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive trigger level |
| thr_empty | input | 1 | Transmit holding register empty |
| line_err | input | 1 | Receive line status error pending |
| modem_chg | input | 1 | Modem status change pending |
| irq | output | 1 | Interrupt request, active high |

## Verification
The embedded assertions check the following on every cycle:
- the mask update and hold rules;
- that a cleared mask silences `irq`;
- that an enabled transmit-empty source always raises `irq`;
- that in FIFO mode a count below the trigger never raises a receive-only request;
- that outside FIFO mode the data-ready flag alone drives it.

The bench scenarios cover what the assertions do not. These are the reset contents before any write, the read-back value of the upper bits, and the trigger-level sweep across the boundary from below, at, and above the trigger. They also cover the rule that a zero count never triggers, the same-cycle response to a status change, and the one-cycle delay of a mask write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int REG_W   = 8;

  localparam int SRC_RX    = 0;
  localparam int SRC_THRE  = 1;
  localparam int SRC_LINE  = 2;
  localparam int SRC_MODEM = 3;

  typedef struct packed {
    logic modem;
    logic line;
    logic thre;
    logic rx;
  } irq_src_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output irq_src_t         mask,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - NUM_SRC;

  irq_src_t mask_q;
  irq_src_t mask_nxt;
  logic     unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:NUM_SRC];

  always_comb begin
    mask_nxt = mask_q;
    if (wr_en) begin
      mask_nxt = irq_src_t'(wr_data[NUM_SRC-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q <= mask_nxt;
    end
  end

  assign mask    = mask_q;
  assign rd_data = {{PAD_W{1'b0}}, mask_q};

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> rd_data[NUM_SRC-1:0] == $past(wr_data[NUM_SRC-1:0])); // R2

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(rd_data)); // R3
endmodule

// File: rtl/irq_rx_level.sv
module irq_rx_level #(
  parameter int CNT_W = 5
) (
  input  logic             fifo_mode,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trigger,
  output logic             rx_pend
);
  logic at_level;
  logic non_empty;

  always_comb begin
    non_empty = (count != '0);
    at_level  = non_empty && (count >= trigger);
    rx_pend   = fifo_mode ? at_level : data_ready;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import uart_irq_pkg::*;
(
  input  irq_src_t mask,
  input  irq_src_t pend,
  output logic     irq
);
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] mask_v;
  logic [NUM_SRC-1:0] pend_v;

  assign mask_v = mask;
  assign pend_v = pend;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = mask_v[g] & pend_v[g];
  end

  assign irq = |hit;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             fifo_mode,
  input  logic             rx_data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             thr_empty,
  input  logic             line_err,
  input  logic             modem_chg,
  output logic             irq
);
  logic     rst_n_sync;
  irq_src_t mask;
  irq_src_t pend;
  logic     rx_pend;

  irq_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_mask_reg i_mask_reg (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .mask    (mask),
    .rd_data (reg_rdata)
  );

  irq_rx_level #(.CNT_W(CNT_W)) i_rx_level (
    .fifo_mode  (fifo_mode),
    .data_ready (rx_data_ready),
    .count      (rx_count),
    .trigger    (rx_trigger),
    .rx_pend    (rx_pend)
  );

  always_comb begin
    pend.rx    = rx_pend;
    pend.thre  = thr_empty;
    pend.line  = line_err;
    pend.modem = modem_chg;
  end

  irq_merge i_merge (
    .mask (mask),
    .pend (pend),
    .irq  (irq)
  );

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_rdata[NUM_SRC-1:0] == '0) |-> !irq); // R9

  AST_THRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_rdata[SRC_THRE] && thr_empty) |-> irq); // R6

  AST_RX_BELOW_TRIG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (fifo_mode && (rx_count < rx_trigger) && reg_rdata[NUM_SRC-1:0] == 4'b0001) |-> !irq); // R5

  AST_RX_DIRECT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!fifo_mode && reg_rdata[NUM_SRC-1:0] == 4'b0001) |-> (irq == rx_data_ready)); // R4
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int FIFO_DEPTH = 16;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  typedef struct {
    logic       irq;
    logic [7:0] rdata;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic             fifo_mode = 1'b0;
  logic             rx_data_ready = 1'b0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] rx_trigger = '0;
  logic             thr_empty = 1'b0;
  logic             line_err = 1'b0;
  logic             modem_chg = 1'b0;
  logic             irq;

  logic [3:0] model_mask = 4'h0;
  exp_t       sb_q[$];
  event       ev_chk;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) i_uart_irq_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .fifo_mode     (fifo_mode),
    .rx_data_ready (rx_data_ready),
    .rx_count      (rx_count),
    .rx_trigger    (rx_trigger),
    .thr_empty     (thr_empty),
    .line_err      (line_err),
    .modem_chg     (modem_chg),
    .irq           (irq)
  );

  function automatic logic model_irq();
    logic rx_p;
    rx_p = fifo_mode ? ((rx_count != '0) && (rx_count >= rx_trigger)) : rx_data_ready;
    return (model_mask[0] & rx_p) | (model_mask[1] & thr_empty) |
           (model_mask[2] & line_err) | (model_mask[3] & modem_chg);
  endfunction

  // Monitor: pops expected items and compares 2 ns before the rising edge.
  initial begin
    forever begin
      @(ev_chk);
      #8;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (irq !== e.irq || reg_rdata !== e.rdata) begin
          n_fail++;
          $display("FAIL %s: irq=%b rdata=%h expected irq=%b rdata=%h",
                   e.tag, irq, reg_rdata, e.irq, e.rdata);
        end
      end
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e.irq   = model_irq();
    e.rdata = {4'h0, model_mask};
    e.tag   = tag;
    sb_q.push_back(e);
    -> ev_chk;
    @(negedge clk);
  endtask

  task automatic write_mask(input logic [7:0] d);
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr     = 1'b0;
    model_mask = d[3:0];
  endtask

  task automatic set_src(input logic dr, input logic te, input logic le, input logic mc);
    rx_data_ready = dr;
    thr_empty     = te;
    line_err      = le;
    modem_chg     = mc;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    set_src(1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    expect_now("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R1 after release, all pending, mask clear");

    // R2: write all ones, upper bits read zero
    write_mask(8'hFF);
    expect_now("R2 readback 0xFF->0x0F");
    // R3: data changes without strobe have no effect
    reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    expect_now("R3 mask held without write");

    // R10: write takes effect only after the edge
    write_mask(8'h00);
    expect_now("R9 all masked quiet");
    set_src(1'b0, 1'b0, 1'b0, 1'b0);
    reg_wr = 1'b1; reg_wdata = 8'h02; thr_empty = 1'b1;
    #8;
    n_chk++;
    if (irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: irq=%b before write edge expected 0", irq);
    end
    @(negedge clk);
    reg_wr = 1'b0; model_mask = 4'h2;
    expect_now("R10 write visible next cycle / R6 thre");
    thr_empty = 1'b0;
    expect_now("R6 thre cleared, R10 same cycle");

    // R4 non-FIFO receive
    write_mask(8'h01);
    rx_data_ready = 1'b1;
    expect_now("R4 data ready raises");
    rx_data_ready = 1'b0;
    expect_now("R4 data ready low");
    thr_empty = 1'b1; line_err = 1'b1; modem_chg = 1'b1;
    expect_now("R9 disabled sources ignored");
    set_src(1'b0, 1'b0, 1'b0, 1'b0);

    // R5 FIFO mode sweep
    fifo_mode = 1'b1; rx_trigger = 5'd8;
    for (int c = 6; c <= 10; c++) begin
      rx_count = CNT_W'(c);
      expect_now($sformatf("R5 count %0d trig 8", c));
    end
    rx_count = 5'd7;
    expect_now("R5 falls below trigger clears");
    rx_data_ready = 1'b1;
    expect_now("R5 data ready ignored in FIFO mode");
    rx_count = 5'd0; rx_trigger = 5'd0;
    expect_now("R5 zero count never triggers");
    rx_count = 5'd16; rx_trigger = 5'd16;
    expect_now("R5 full at trigger 16");
    rx_trigger = 5'd1; rx_count = 5'd1;
    expect_now("R5 trigger 1 count 1");
    fifo_mode = 1'b0; rx_count = '0; rx_data_ready = 1'b0;

    // R7, R8 individual sources
    write_mask(8'h04);
    line_err = 1'b1;
    expect_now("R7 line error enabled");
    modem_chg = 1'b1; line_err = 1'b0;
    expect_now("R8 modem masked by bit2-only mask");
    write_mask(8'h08);
    expect_now("R8 modem enabled");
    modem_chg = 1'b0;
    expect_now("R8 modem cleared");

    // R9 combined OR
    write_mask(8'h0E);
    line_err = 1'b1; thr_empty = 1'b1;
    expect_now("R9 multiple sources");
    line_err = 1'b0; thr_empty = 1'b0; rx_data_ready = 1'b1;
    expect_now("R9 only masked rx pending");

    // R1 reset clears mask again
    rst_n = 1'b0;
    @(negedge clk);
    model_mask = 4'h0;
    set_src(1'b1, 1'b1, 1'b1, 1'b1);
    expect_now("R1 reset clears mask");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule